// File: doc/BRIEF.md
# Dual Accumulator Register Unit

This block is the register core of a small 8-bit processor datapath. It keeps two 8-bit accumulators, A and B, that can also be loaded and read together as a single 16-bit double accumulator. It also keeps two 16-bit index registers, X and Y, and an 8-bit flag register. A sequencer outside the block writes registers through one write port and reads every register at once from dedicated read ports.

An operation code selects one of a handful of register-to-register operations each cycle. The set is deliberately lopsided. Only B can be added to an index register. Only A can be exchanged with the flag register or decimal-adjusted. Accumulator arithmetic always computes A op B, and the result always returns to A. Every register updates on the rising clock edge, so a result is visible on the read ports in the cycle after the operation is presented.

Top module: `dacc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, A, B, X, Y and the flag register all become zero.
- R2: With `wr_en` high, `wr_sel` chooses the target of `wr_data`: 0 = A (low byte), 1 = B (low byte), 2 = double accumulator (A takes bits 15:8, B takes bits 7:0, same edge), 3 = X, 4 = Y, 5 = flags (low byte). `acc_d` always reads as {A, B}.
- R3: Operation code 1 adds B, zero-extended, to X. Code 2 does the same to Y. The sum wraps modulo 2^16, the other index register keeps its value and the flags are unchanged.
- R4: Code 3 copies A into all eight flag bits. Code 4 copies the flag register into A and leaves the flags unchanged.
- R5: Code 6 sets A to A+B modulo 256. Flag bits use the positions 7 S, 6 X, 5 H, 4 I, 3 N, 2 Z, 1 V, 0 C. H is the carry out of bit 3 and C is the carry out of bit 7. V is signed overflow, N is bit 7 of the result and Z means the result is zero. S, X and I are kept.
- R6: Code 7 sets A to A-B modulo 256. N, Z, V and C are updated, with C set when B is greater than A unsigned. H, S, X and I are kept.
- R7: Code 8 updates the flags exactly as code 7 would and leaves A unchanged.
- R8: Code 5 adds 0x06 to A when H is set or the low nibble of A exceeds 9. It adds 0x60 when C is set or A exceeds 0x99. C becomes the old C OR the 0x60 condition, N and Z follow the result, and H, V, S, X and I are kept.
- R9: No operation code changes B. Codes 0 and 9 to 15 change no register.
- R10: When a write and an operation target the same register in one cycle, the written value is stored. Registers that only the operation targets still take its result, and that result is computed from the values held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation select (0 = none) |
| wr_en | input | 1 | Write port enable |
| wr_sel | input | 3 | Write port target register |
| wr_data | input | 16 | Write port data |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| acc_d | output | 16 | Double accumulator {A, B} |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| ccr | output | 8 | Flag register |

## Verification
A load through the write port and an operation can land in the same cycle. The bench provokes this on purpose in three ways. An accumulator add is paired with a load of A. An index add on X is paired with a double-accumulator load that replaces B. A flag transfer is paired with a load of the flags. Each case is judged at the read ports. The loaded value must win on the shared register, the operation's other results must still appear, and those results must have been computed from the operand values that stood before the edge.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    localparam int ACC_W = 8;
    localparam int IDX_W = 16;
    localparam int DBL_W = 2 * ACC_W;
    localparam int N_IDX = 2;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_ADD_BX = 4'd1,
        OP_ADD_BY = 4'd2,
        OP_A_TO_CC = 4'd3,
        OP_CC_TO_A = 4'd4,
        OP_DEC_ADJ = 4'd5,
        OP_ADD_AB = 4'd6,
        OP_SUB_AB = 4'd7,
        OP_CMP_AB = 4'd8
    } op_e;

    typedef enum logic [2:0] {
        SEL_A = 3'd0,
        SEL_B = 3'd1,
        SEL_D = 3'd2,
        SEL_X = 3'd3,
        SEL_Y = 3'd4,
        SEL_CC = 3'd5
    } sel_e;

    typedef struct packed {
        logic s;
        logic x;
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic [ACC_W-1:0] a;
        ccr_t cc;
        logic wr_a;
        logic wr_cc;
    } alu_res_t;

    function automatic logic nib_over9(input logic [3:0] nib);
        return nib > 4'd9;
    endfunction

    function automatic logic idx_targets(input op_e op, input int k);
        return (k == 0) ? (op == OP_ADD_BX) : (op == OP_ADD_BY);
    endfunction

endpackage

// File: rtl/dacc_alu.sv
module dacc_alu
    import dacc_pkg::*;
(
    input  op_e              op,
    input  logic [ACC_W-1:0] a_in,
    input  logic [ACC_W-1:0] b_in,
    input  ccr_t             cc_in,
    output alu_res_t         res
);

    localparam int MSB = ACC_W - 1;

    logic [ACC_W:0]   sum_w;
    logic [4:0]       nib_sum;
    logic [ACC_W:0]   dif_w;
    logic             fix_lo;
    logic             fix_hi;
    logic [ACC_W-1:0] adj_val;
    logic [ACC_W-1:0] adj_res;

    always_comb begin
        sum_w   = {1'b0, a_in} + {1'b0, b_in};
        nib_sum = {1'b0, a_in[3:0]} + {1'b0, b_in[3:0]};
        dif_w   = {1'b0, a_in} - {1'b0, b_in};
        fix_lo  = cc_in.h | nib_over9(a_in[3:0]);
        fix_hi  = cc_in.c | (a_in > 8'h99);
        adj_val = {(fix_hi ? 4'h6 : 4'h0), (fix_lo ? 4'h6 : 4'h0)};
        adj_res = a_in + adj_val;
    end

    always_comb begin
        res       = '0;
        res.a     = a_in;
        res.cc    = cc_in;
        res.wr_a  = 1'b0;
        res.wr_cc = 1'b0;
        unique case (op)
            OP_A_TO_CC: begin
                res.cc    = ccr_t'(a_in);
                res.wr_cc = 1'b1;
            end
            OP_CC_TO_A: begin
                res.a    = a_in;
                res.a    = cc_in;
                res.wr_a = 1'b1;
            end
            OP_ADD_AB: begin
                res.a     = sum_w[MSB:0];
                res.cc.h  = nib_sum[4];
                res.cc.n  = sum_w[MSB];
                res.cc.z  = (sum_w[MSB:0] == '0);
                res.cc.v  = (a_in[MSB] == b_in[MSB]) && (sum_w[MSB] != a_in[MSB]);
                res.cc.c  = sum_w[ACC_W];
                res.wr_a  = 1'b1;
                res.wr_cc = 1'b1;
            end
            OP_SUB_AB, OP_CMP_AB: begin
                res.a     = dif_w[MSB:0];
                res.cc.n  = dif_w[MSB];
                res.cc.z  = (dif_w[MSB:0] == '0);
                res.cc.v  = (a_in[MSB] != b_in[MSB]) && (dif_w[MSB] != a_in[MSB]);
                res.cc.c  = dif_w[ACC_W];
                res.wr_a  = (op == OP_SUB_AB);
                res.wr_cc = 1'b1;
            end
            OP_DEC_ADJ: begin
                res.a     = adj_res;
                res.cc.n  = adj_res[MSB];
                res.cc.z  = (adj_res == '0);
                res.cc.c  = cc_in.c | fix_hi;
                res.wr_a  = 1'b1;
                res.wr_cc = 1'b1;
            end
            default: begin
                res.wr_a  = 1'b0;
                res.wr_cc = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dacc_idx_add.sv
module dacc_idx_add #(
    parameter int IW = 16,
    parameter int BW = 8
) (
    input  logic          en,
    input  logic [IW-1:0] idx_in,
    input  logic [BW-1:0] b_in,
    output logic [IW-1:0] idx_out
);

    localparam int PAD = IW - BW;

    logic [IW-1:0] b_ext;

    always_comb begin
        b_ext   = {{PAD{1'b0}}, b_in};
        idx_out = en ? (idx_in + b_ext) : idx_in;
    end

endmodule

// File: rtl/dacc_unit.sv
module dacc_unit
    import dacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op_code,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [DBL_W-1:0] wr_data,
    output logic [ACC_W-1:0] acc_a,
    output logic [ACC_W-1:0] acc_b,
    output logic [DBL_W-1:0] acc_d,
    output logic [IDX_W-1:0] idx_x,
    output logic [IDX_W-1:0] idx_y,
    output logic [ACC_W-1:0] ccr
);

    op_e              op;
    sel_e             sel;
    logic [ACC_W-1:0] a_q, b_q, a_n, b_n;
    ccr_t             cc_q, cc_n;
    logic [IDX_W-1:0] idx_q   [N_IDX];
    logic [IDX_W-1:0] idx_sum [N_IDX];
    logic [IDX_W-1:0] idx_n   [N_IDX];
    alu_res_t         alu_r;

    assign op  = op_e'(op_code);
    assign sel = sel_e'(wr_sel);

    dacc_alu u_alu (
        .op    (op),
        .a_in  (a_q),
        .b_in  (b_q),
        .cc_in (cc_q),
        .res   (alu_r)
    );

    for (genvar k = 0; k < N_IDX; k++) begin : g_idx
        dacc_idx_add #(.IW(IDX_W), .BW(ACC_W)) u_add (
            .en      (idx_targets(op, k)),
            .idx_in  (idx_q[k]),
            .b_in    (b_q),
            .idx_out (idx_sum[k])
        );
    end

    // Operation results first, then the write port overrides its target.
    always_comb begin
        a_n   = alu_r.wr_a  ? alu_r.a  : a_q;
        cc_n  = alu_r.wr_cc ? alu_r.cc : cc_q;
        b_n   = b_q;
        idx_n = idx_sum;
        if (wr_en) begin
            case (sel)
                SEL_A:  a_n = wr_data[ACC_W-1:0];
                SEL_B:  b_n = wr_data[ACC_W-1:0];
                SEL_D: begin
                    a_n = wr_data[DBL_W-1:ACC_W];
                    b_n = wr_data[ACC_W-1:0];
                end
                SEL_X:  idx_n[0] = wr_data[IDX_W-1:0];
                SEL_Y:  idx_n[1] = wr_data[IDX_W-1:0];
                SEL_CC: cc_n = ccr_t'(wr_data[ACC_W-1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            b_q  <= '0;
            cc_q <= '0;
            for (int k = 0; k < N_IDX; k++) idx_q[k] <= '0;
        end else begin
            a_q   <= a_n;
            b_q   <= b_n;
            cc_q  <= cc_n;
            idx_q <= idx_n;
        end
    end

    assign acc_a = a_q;
    assign acc_b = b_q;
    assign acc_d = {a_q, b_q};
    assign idx_x = idx_q[0];
    assign idx_y = idx_q[1];
    assign ccr   = cc_q;

    logic wr_hits_a, wr_hits_b, wr_hits_cc;
    assign wr_hits_a  = wr_en && (wr_sel == SEL_A || wr_sel == SEL_D);
    assign wr_hits_b  = wr_en && (wr_sel == SEL_B || wr_sel == SEL_D);
    assign wr_hits_cc = wr_en && (wr_sel == SEL_CC);

    // R9: only the write port may change B
    p_b_only_by_write_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_hits_b |=> $stable(b_q));

    // R3: index add leaves the flags alone
    p_idx_add_keeps_cc_r3: assert property (@(posedge clk) disable iff (rst)
        ((op_code == OP_ADD_BX || op_code == OP_ADD_BY) && !wr_hits_cc) |=> $stable(cc_q));

    // R7: compare leaves A alone
    p_cmp_keeps_a_r7: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_CMP_AB && !wr_hits_a) |=> $stable(a_q));

    // R4: transfer A to flags
    p_a_to_cc_r4: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_A_TO_CC && !wr_hits_cc) |=> (cc_q == $past(a_q)));

    // R5: accumulator add
    p_add_sum_r5: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_ADD_AB && !wr_hits_a) |=> (a_q == ACC_W'($past(a_q) + $past(b_q))));

    // R10: write port wins over operation on A
    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_A) |=> (a_q == $past(wr_data[ACC_W-1:0])));

endmodule

// File: tb/dacc_unit_test.sv
`timescale 1ns/1ps
module dacc_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  acc_a, acc_b, ccr;
    logic [15:0] acc_d, idx_x, idx_y;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dacc_unit uut (
        .clk(clk), .rst(rst), .op_code(op_code), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .acc_a(acc_a), .acc_b(acc_b),
        .acc_d(acc_d), .idx_x(idx_x), .idx_y(idx_y), .ccr(ccr)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] op, input logic we, input logic [2:0] sel,
                       input logic [15:0] d);
        op_code = op; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        op_code = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        cyc(4'd0, 1'b1, sel, d);
    endtask

    task automatic run(input logic [3:0] op);
        cyc(op, 1'b0, 3'd0, 16'h0);
    endtask

    task automatic t_reset;
        chk("R1 a after reset", acc_a, 0);
        chk("R1 d after reset", acc_d, 0);
        chk("R1 x after reset", idx_x, 0);
        chk("R1 y after reset", idx_y, 0);
        chk("R1 cc after reset", ccr, 0);
        wr(3, 16'hBEEF); wr(4, 16'h1234); wr(5, 16'h00FF); wr(2, 16'h5566);
        rst = 1'b1; @(posedge clk); #1; rst = 1'b0;
        chk("R1 d cleared", acc_d, 0);
        chk("R1 x cleared", idx_x, 0);
        chk("R1 y cleared", idx_y, 0);
        chk("R1 cc cleared", ccr, 0);
    endtask

    task automatic t_write;
        wr(2, 16'h1234);
        chk("R2 d write hi to a", acc_a, 16'h12);
        chk("R2 d write lo to b", acc_b, 16'h34);
        wr(0, 16'hFFAB);
        wr(1, 16'h00CD);
        chk("R2 d reads a,b", acc_d, 16'hABCD);
        wr(3, 16'hFFF0); wr(4, 16'h1234); wr(5, 16'h115A);
        chk("R2 x write", idx_x, 16'hFFF0);
        chk("R2 y write", idx_y, 16'h1234);
        chk("R2 cc write low byte", ccr, 16'h5A);
    endtask

    task automatic t_index;
        wr(1, 16'h0020);
        run(4'd1);
        chk("R3 x wraps", idx_x, 16'h0010);
        chk("R3 y untouched by x add", idx_y, 16'h1234);
        chk("R3 cc kept", ccr, 16'h5A);
        wr(1, 16'h00FF);
        run(4'd2);
        chk("R3 y add", idx_y, 16'h1333);
        chk("R3 x untouched by y add", idx_x, 16'h0010);
        wr(3, 16'h0100); wr(1, 16'h0080);
        run(4'd1);
        chk("R3 b zero extended", idx_x, 16'h0180);
        chk("R9 b kept by index add", acc_b, 16'h80);
    endtask

    task automatic t_transfer;
        wr(0, 16'h00C3);
        run(4'd3);
        chk("R4 a to cc", ccr, 16'hC3);
        chk("R4 a kept", acc_a, 16'hC3);
        wr(5, 16'h006E); wr(0, 16'h0000);
        run(4'd4);
        chk("R4 cc to a", acc_a, 16'h6E);
        chk("R4 cc kept", ccr, 16'h6E);
    endtask

    task automatic t_add;
        wr(5, 16'h0010); wr(2, 16'h3A48);
        run(4'd6);
        chk("R5 sum", acc_a, 16'h82);
        chk("R5 flags h n v", ccr, 16'h3A);
        chk("R9 b kept by add", acc_b, 16'h48);
        wr(2, 16'hFF01);
        run(4'd6);
        chk("R5 zero sum", acc_a, 16'h00);
        chk("R5 flags h z c", ccr, 16'h35);
    endtask

    task automatic t_sub_cmp;
        wr(5, 16'h0020); wr(2, 16'h1020);
        run(4'd7);
        chk("R6 difference", acc_a, 16'hF0);
        chk("R6 borrow keeps h", ccr, 16'h29);
        wr(2, 16'h8001);
        run(4'd7);
        chk("R6 overflow", acc_a, 16'h7F);
        chk("R6 flags v", ccr, 16'h22);
        wr(5, 16'h0000); wr(2, 16'h5555);
        run(4'd8);
        chk("R7 cmp equal z", ccr, 16'h04);
        chk("R7 cmp a kept", acc_a, 16'h55);
        wr(2, 16'h0102);
        run(4'd8);
        chk("R7 cmp less n c", ccr, 16'h09);
        chk("R7 cmp a kept 2", acc_a, 16'h01);
    endtask

    task automatic t_daa;
        wr(5, 16'h0000); wr(2, 16'h1527);
        run(4'd6); run(4'd5);
        chk("R8 low nibble fix", acc_a, 16'h42);
        chk("R8 flags clear", ccr, 16'h00);
        wr(5, 16'h0000); wr(2, 16'h0908);
        run(4'd6); run(4'd5);
        chk("R8 half carry fix", acc_a, 16'h17);
        chk("R8 h kept", ccr, 16'h20);
        wr(5, 16'h0000); wr(2, 16'h9901);
        run(4'd6); run(4'd5);
        chk("R8 both fixes", acc_a, 16'h00);
        chk("R8 carry zero", ccr, 16'h05);
        wr(5, 16'h0000); wr(2, 16'h9090);
        run(4'd6); run(4'd5);
        chk("R8 carry fix", acc_a, 16'h80);
        chk("R8 carry kept v kept", ccr, 16'h0B);
    endtask

    task automatic t_unused;
        wr(2, 16'hA5C3); wr(3, 16'h1111); wr(4, 16'h2222); wr(5, 16'h0033);
        for (int c = 9; c < 16; c++) run(4'(c));
        run(4'd0);
        chk("R9 unused codes d", acc_d, 16'hA5C3);
        chk("R9 unused codes x", idx_x, 16'h1111);
        chk("R9 unused codes y", idx_y, 16'h2222);
        chk("R9 unused codes cc", ccr, 16'h33);
    endtask

    task automatic t_collide;
        wr(5, 16'h00FF); wr(2, 16'h1005);
        cyc(4'd6, 1'b1, 3'd0, 16'h0077);
        chk("R10 write wins on a", acc_a, 16'h77);
        chk("R10 add flags still land", ccr, 16'hD0);
        wr(3, 16'h0100);
        cyc(4'd1, 1'b1, 3'd2, 16'hABCD);
        chk("R10 x uses old b", idx_x, 16'h0105);
        chk("R10 d write lands", acc_d, 16'hABCD);
        cyc(4'd3, 1'b1, 3'd5, 16'h0011);
        chk("R10 write wins on cc", ccr, 16'h11);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_write();
        t_index();
        t_transfer();
        t_add();
        t_sub_cmp();
        t_daa();
        t_unused();
        t_collide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule